// File: doc/BRIEF.md
# Message-Signalled Interrupt Receiver and Controller

This block collects message-signalled interrupts that downstream devices post as doorbell writes and folds them into a single interrupt line for the processor. Each doorbell write carries a data word. The word, taken modulo the vector count, picks one of 32 vectors and marks it pending. A processor-side register port lets software read the pending set and acknowledge vectors. A pending bit is cleared by writing 0 to it. The same port enables or masks vectors through a pair of write-one-to-set and write-one-to-clear addresses.

The block also latches error events into an error status word that is cleared the same way, by writing zeros. A separate read-only raw view of that word is provided. Four legacy interrupt inputs are gated by their own enable bits, which are set and cleared through a separate pair of addresses.

Software normally drains vectors in a loop. It reads the pending word, services the lowest set bit, acknowledges it, and reads again until the word is zero. Register reads are combinational from the current address. Register writes and doorbells take effect at the next rising clock edge.

Top module: `msi_irq_ctrl`

## Requirements
- R1: After reset, every register reads zero, and msiIrq, errIrq and legIrq are low.
- R2: A doorbell write with data value n sets pending bit (n mod 32). The bit can be read at word address 0 after the next clock edge.
- R3: A register write to address 0 clears each pending bit whose write-data bit is 0. Pending bits written as 1 are left unchanged.
- R4: A write to address 1 enables every vector whose data bit is 1. A write to address 2 disables every vector whose data bit is 1. Data bits of 0 have no effect at either address. Reading address 1 or 2 returns the enable word.
- R5: msiIrq is high exactly when some vector is both pending and enabled. It reflects register state from the previous clock edge.
- R6: The pending word read at address 0 is not masked by the enables.
- R7: If a doorbell and a zero-write acknowledge hit the same pending bit in the same cycle, the bit stays set. The same holds for an error event and an error-status clear.
- R8: A high bit on errEvent sets the matching error status bit. Writing 0 to a bit at address 4 clears it. Address 3 returns the same error bits as a read-only raw view, and writes there are ignored. errIrq is high when any error bit is set.
- R9: A write to address 5 sets, and a write to address 6 clears, the four legacy enables, using data bits 3:0; higher data bits are ignored. Reading either address returns the enables in bits 3:0. legIrq is the OR of legIn AND the enables.
- R10: Reads of address 7 return zero, and writes to address 7 change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| dbValid | input | 1 | Doorbell write strobe |
| dbData | input | 32 | Doorbell write data; the value modulo 32 selects the vector |
| regWe | input | 1 | Register write strobe |
| regAddr | input | 3 | Register word address |
| regWdata | input | 32 | Register write data |
| regRdata | output | 32 | Register read data for regAddr |
| errEvent | input | 8 | Error event pulses, one per error bit |
| legIn | input | 4 | Legacy interrupt request levels |
| msiIrq | output | 1 | Aggregated message interrupt |
| errIrq | output | 1 | Any error status bit set |
| legIrq | output | 1 | Any enabled legacy request active |

## Verification
The bench attacks the write-zero acknowledge. A design that treated writes as write-one-to-clear would wipe the wrong vectors, so the acknowledge of a single vector and an all-ones no-op write are both checked. Doorbell values above 31 are used to catch a design that drops them instead of wrapping them. Same-cycle doorbell/acknowledge and event/clear collisions expose a design where the clear wins and a message is lost. A drain loop that always takes the lowest bit confirms that the loop ends, and that masked-but-pending vectors still appear in the status while holding msiIrq low.

// File: rtl/msi_irq_pkg.sv
package msi_irq_pkg;

  // Register word addresses; software depends on these values.
  localparam int unsigned OFS_PEND    = 0;
  localparam int unsigned OFS_ENSET   = 1;
  localparam int unsigned OFS_ENCLR   = 2;
  localparam int unsigned OFS_ERRRAW  = 3;
  localparam int unsigned OFS_ERRSTAT = 4;
  localparam int unsigned OFS_LEGSET  = 5;
  localparam int unsigned OFS_LEGCLR  = 6;

  typedef struct packed {
    logic pendWr;
    logic enSet;
    logic enClr;
    logic errWr;
    logic legSet;
    logic legClr;
  } strobe_t;

  typedef enum logic [2:0] {
    SEL_PEND,
    SEL_EN,
    SEL_ERR,
    SEL_LEG,
    SEL_NONE
  } rdsel_t;

endpackage

// File: rtl/msi_irq_ctl.sv
module msi_irq_ctl
  import msi_irq_pkg::*;
#(
  parameter int unsigned ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic [ADDR_W-1:0] regAddr,
  output strobe_t           stb,
  output rdsel_t            rdSel
);

  always_comb begin
    stb   = '0;
    rdSel = SEL_NONE;
    case (regAddr)
      ADDR_W'(OFS_PEND): begin
        rdSel      = SEL_PEND;
        stb.pendWr = regWe;
      end
      ADDR_W'(OFS_ENSET): begin
        rdSel     = SEL_EN;
        stb.enSet = regWe;
      end
      ADDR_W'(OFS_ENCLR): begin
        rdSel     = SEL_EN;
        stb.enClr = regWe;
      end
      ADDR_W'(OFS_ERRRAW): begin
        rdSel = SEL_ERR;  // read-only view, write dropped
      end
      ADDR_W'(OFS_ERRSTAT): begin
        rdSel     = SEL_ERR;
        stb.errWr = regWe;
      end
      ADDR_W'(OFS_LEGSET): begin
        rdSel      = SEL_LEG;
        stb.legSet = regWe;
      end
      ADDR_W'(OFS_LEGCLR): begin
        rdSel      = SEL_LEG;
        stb.legClr = regWe;
      end
      default: ;
    endcase
  end

  // At most one register is written per cycle (R10: unmapped writes none)
  assert_one_strobe_R10 : assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(stb));

  // Writes only happen when the write strobe is high (R10)
  assert_no_strobe_idle_R10 : assert property (@(posedge clk) disable iff (!rstN)
    !regWe |-> (stb == '0));

endmodule

// File: rtl/msi_irq_dp.sv
module msi_irq_dp
  import msi_irq_pkg::*;
#(
  parameter int unsigned NUM_VEC = 32,
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned ERR_W   = 8,
  parameter int unsigned LEG_N   = 4,
  localparam int unsigned VEC_W  = $clog2(NUM_VEC)
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           stb,
  input  rdsel_t            rdSel,
  input  logic [DATA_W-1:0] wdata,
  input  logic              dbValid,
  input  logic [VEC_W-1:0]  dbVec,
  input  logic [ERR_W-1:0]  errEvent,
  input  logic [LEG_N-1:0]  legIn,
  output logic [DATA_W-1:0] rdata,
  output logic              msiIrq,
  output logic              errIrq,
  output logic              legIrq
);

  logic [NUM_VEC-1:0] pendQ, enQ;
  logic [ERR_W-1:0]   errQ;
  logic [LEG_N-1:0]   legEnQ;

  // Per-vector pending and enable bits
  for (genvar v = 0; v < NUM_VEC; v++) begin : g_vec
    logic hit, ackZero;
    assign hit     = dbValid && (dbVec == VEC_W'(v));
    assign ackZero = stb.pendWr && !wdata[v];
    always_ff @(posedge clk) begin
      if (!rstN) begin
        pendQ[v] <= 1'b0;
        enQ[v]   <= 1'b0;
      end else begin
        // set beats clear on a collision (R7)
        pendQ[v] <= hit | (pendQ[v] & !ackZero);
        if (stb.enSet && wdata[v])      enQ[v] <= 1'b1;
        else if (stb.enClr && wdata[v]) enQ[v] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      errQ   <= '0;
      legEnQ <= '0;
    end else begin
      errQ <= errEvent | (errQ & (stb.errWr ? wdata[ERR_W-1:0] : {ERR_W{1'b1}}));
      if (stb.legSet)      legEnQ <= legEnQ | wdata[LEG_N-1:0];
      else if (stb.legClr) legEnQ <= legEnQ & ~wdata[LEG_N-1:0];
    end
  end

  assign msiIrq = |(pendQ & enQ);
  assign errIrq = |errQ;
  assign legIrq = |(legIn & legEnQ);

  always_comb begin
    case (rdSel)
      SEL_PEND: rdata = DATA_W'(pendQ);
      SEL_EN:   rdata = DATA_W'(enQ);
      SEL_ERR:  rdata = DATA_W'(errQ);
      SEL_LEG:  rdata = DATA_W'(legEnQ);
      default:  rdata = '0;
    endcase
  end

  assert_db_sets_R2 : assert property (@(posedge clk) disable iff (!rstN)
    dbValid |=> pendQ[$past(dbVec)]);

  assert_ack_keeps_ones_R3 : assert property (@(posedge clk) disable iff (!rstN)
    (stb.pendWr && !dbValid) |=>
      (((pendQ ^ $past(pendQ)) & $past(wdata[NUM_VEC-1:0])) == '0));

  assert_ack_never_sets_R3 : assert property (@(posedge clk) disable iff (!rstN)
    !dbValid |=> ((pendQ & ~$past(pendQ)) == '0));

  assert_en_set_R4 : assert property (@(posedge clk) disable iff (!rstN)
    stb.enSet |=> ((enQ & $past(wdata[NUM_VEC-1:0])) == $past(wdata[NUM_VEC-1:0])));

  assert_en_clr_R4 : assert property (@(posedge clk) disable iff (!rstN)
    stb.enClr |=> ((enQ & $past(wdata[NUM_VEC-1:0])) == '0));

  assert_irq_needs_both_R5 : assert property (@(posedge clk) disable iff (!rstN)
    msiIrq |-> ((pendQ != '0) && (enQ != '0)));

  assert_err_event_R8 : assert property (@(posedge clk) disable iff (!rstN)
    (errEvent != '0) |=> errIrq);

endmodule

// File: rtl/msi_irq_ctrl.sv
module msi_irq_ctrl
  import msi_irq_pkg::*;
#(
  parameter int unsigned NUM_VEC = 32,
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned ADDR_W  = 3,
  parameter int unsigned ERR_W   = 8,
  parameter int unsigned LEG_N   = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              dbValid,
  input  logic [DATA_W-1:0] dbData,
  input  logic              regWe,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWdata,
  output logic [DATA_W-1:0] regRdata,
  input  logic [ERR_W-1:0]  errEvent,
  input  logic [LEG_N-1:0]  legIn,
  output logic              msiIrq,
  output logic              errIrq,
  output logic              legIrq
);

  localparam int unsigned VEC_W = $clog2(NUM_VEC);

  strobe_t          stb;
  rdsel_t           rdSel;
  logic [VEC_W-1:0] dbVec;

  assign dbVec = VEC_W'(dbData % DATA_W'(NUM_VEC));

  msi_irq_ctl #(.ADDR_W(ADDR_W)) ctl_i (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr),
    .stb(stb), .rdSel(rdSel)
  );

  msi_irq_dp #(
    .NUM_VEC(NUM_VEC), .DATA_W(DATA_W), .ERR_W(ERR_W), .LEG_N(LEG_N)
  ) dp_i (
    .clk(clk), .rstN(rstN), .stb(stb), .rdSel(rdSel), .wdata(regWdata),
    .dbValid(dbValid), .dbVec(dbVec), .errEvent(errEvent), .legIn(legIn),
    .rdata(regRdata), .msiIrq(msiIrq), .errIrq(errIrq), .legIrq(legIrq)
  );

endmodule

// File: tb/msi_irq_ctrl_tb.sv
`timescale 1ns/1ps
module msi_irq_ctrl_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        dbValid = 1'b0;
  logic [31:0] dbData = '0;
  logic        regWe = 1'b0;
  logic [2:0]  regAddr = '0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic [7:0]  errEvent = '0;
  logic [3:0]  legIn = '0;
  logic        msiIrq, errIrq, legIrq;

  int nChecks = 0;
  int nFails = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  msi_irq_ctrl dut_i (
    .clk(clk), .rstN(rstN), .dbValid(dbValid), .dbData(dbData),
    .regWe(regWe), .regAddr(regAddr), .regWdata(regWdata), .regRdata(regRdata),
    .errEvent(errEvent), .legIn(legIn),
    .msiIrq(msiIrq), .errIrq(errIrq), .legIrq(legIrq)
  );

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic regWrite(logic [2:0] a, logic [31:0] d);
    @(negedge clk);
    regWe = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk);
    regWe = 1'b0;
  endtask

  task automatic regRead(logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    regAddr = a;
    #1 d = regRdata;
  endtask

  task automatic ring(logic [31:0] d);
    @(negedge clk);
    dbValid = 1'b1; dbData = d;
    @(negedge clk);
    dbValid = 1'b0;
  endtask

  task automatic t_reset;
    logic [31:0] r;
    for (int a = 0; a < 8; a++) begin
      regRead(3'(a), r);
      check("R1", $sformatf("reset read addr %0d", a), r, 32'h0);
    end
    check("R1", "reset msiIrq", {31'h0, msiIrq}, 32'h0);
    check("R1", "reset errIrq", {31'h0, errIrq}, 32'h0);
    check("R1", "reset legIrq", {31'h0, legIrq}, 32'h0);
  endtask

  task automatic t_doorbell;
    logic [31:0] r;
    ring(32'd3);
    ring(32'd40);   // wraps to 8
    ring(32'd31);
    regRead(3'd0, r);
    check("R2", "pending after doorbells 3,40,31", r, 32'h8000_0108);
    check("R6", "pending visible with no enables, irq low", {31'h0, msiIrq}, 32'h0);
  endtask

  task automatic t_enable;
    logic [31:0] r;
    regWrite(3'd1, 32'h0000_0108);
    regRead(3'd1, r);
    check("R4", "enable set read", r, 32'h0000_0108);
    check("R5", "irq with pending+enabled", {31'h0, msiIrq}, 32'h1);
    regWrite(3'd1, 32'h0);
    regRead(3'd2, r);
    check("R4", "enable set with zeros no effect", r, 32'h0000_0108);
    regWrite(3'd2, 32'h0000_0100);
    regRead(3'd1, r);
    check("R4", "enable clear bit 8", r, 32'h0000_0008);
    check("R5", "irq still high via vector 3", {31'h0, msiIrq}, 32'h1);
    regWrite(3'd2, 32'h0000_0008);
    check("R5", "irq low when all masked", {31'h0, msiIrq}, 32'h0);
    regRead(3'd0, r);
    check("R6", "pending unmasked after masking", r, 32'h8000_0108);
  endtask

  task automatic t_ack;
    logic [31:0] r;
    int order [$];
    regWrite(3'd0, ~32'h0000_0100);
    regRead(3'd0, r);
    check("R3", "ack vector 8", r, 32'h8000_0008);
    regWrite(3'd0, 32'hFFFF_FFFF);
    regRead(3'd0, r);
    check("R3", "all-ones write leaves pending", r, 32'h8000_0008);
    // drain loop, lowest bit first
    for (int guard = 0; guard < 40; guard++) begin
      int low;
      regRead(3'd0, r);
      if (r == 0) break;
      low = 0;
      while (!r[low]) low++;
      order.push_back(low);
      regWrite(3'd0, ~(32'h1 << low));
    end
    check("R3", "drain count", 32'(order.size()), 32'd2);
    if (order.size() == 2) begin
      check("R3", "drain first", 32'(order[0]), 32'd3);
      check("R3", "drain second", 32'(order[1]), 32'd31);
    end
  endtask

  task automatic t_collide;
    logic [31:0] r;
    ring(32'd6);
    @(negedge clk);
    dbValid = 1'b1; dbData = 32'd5;
    regWe = 1'b1; regAddr = 3'd0; regWdata = ~32'h0000_0060;
    @(negedge clk);
    dbValid = 1'b0; regWe = 1'b0;
    regRead(3'd0, r);
    check("R7", "doorbell wins over ack, other bit cleared", r, 32'h0000_0020);
    regWrite(3'd0, 32'h0);
  endtask

  task automatic t_error;
    logic [31:0] r;
    @(negedge clk);
    errEvent = 8'h24;
    @(negedge clk);
    errEvent = 8'h00;
    regRead(3'd4, r);
    check("R8", "error status", r, 32'h24);
    regRead(3'd3, r);
    check("R8", "error raw view", r, 32'h24);
    check("R8", "errIrq high", {31'h0, errIrq}, 32'h1);
    regWrite(3'd3, 32'h0);
    regRead(3'd4, r);
    check("R8", "raw view write ignored", r, 32'h24);
    regWrite(3'd4, ~32'h20);
    regRead(3'd4, r);
    check("R8", "write-zero clears bit 5", r, 32'h04);
    @(negedge clk);
    errEvent = 8'h04; regWe = 1'b1; regAddr = 3'd4; regWdata = 32'h0;
    @(negedge clk);
    errEvent = 8'h00; regWe = 1'b0;
    regRead(3'd4, r);
    check("R7", "error event wins over clear", r, 32'h04);
    regWrite(3'd4, 32'h0);
    check("R8", "errIrq low after clear", {31'h0, errIrq}, 32'h0);
  endtask

  task automatic t_legacy;
    logic [31:0] r;
    legIn = 4'b0101;
    regWrite(3'd5, 32'hF0);
    regRead(3'd5, r);
    check("R9", "upper data bits ignored", r, 32'h0);
    check("R9", "legIrq low with no enables", {31'h0, legIrq}, 32'h0);
    regWrite(3'd5, 32'hF);
    regRead(3'd6, r);
    check("R9", "legacy enable set", r, 32'hF);
    check("R9", "legIrq high", {31'h0, legIrq}, 32'h1);
    regWrite(3'd6, 32'h5);
    regRead(3'd5, r);
    check("R9", "legacy enable clear", r, 32'hA);
    check("R9", "legIrq low after masking active pins", {31'h0, legIrq}, 32'h0);
    legIn = 4'b0000;
  endtask

  task automatic t_unmapped;
    logic [31:0] r;
    ring(32'd12);
    regWrite(3'd7, 32'h0);
    regRead(3'd7, r);
    check("R10", "unmapped read zero", r, 32'h0);
    regRead(3'd0, r);
    check("R10", "unmapped write leaves pending", r, 32'h0000_1000);
    regRead(3'd1, r);
    check("R10", "unmapped write leaves enables", r, 32'h0);
    regRead(3'd5, r);
    check("R10", "unmapped write leaves legacy enables", r, 32'hA);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin : main
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    t_reset;
    t_doorbell;
    t_enable;
    t_ack;
    t_collide;
    t_error;
    t_legacy;
    t_unmapped;
    finished = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

endmodule